// File: doc/BRIEF.md
# DAC Sample Buffer Controller

The block holds a small table of DAC codes that software fills through a byte-wide register port, and it drives a DAC code output from that table. Each table word is written as a low byte and a high nibble at neighbouring addresses. A read pointer picks which word drives the output. The pointer steps forward on a trigger pulse and wraps after a programmable last index. When the table is switched off, word 0 drives the output directly and the pointer stays where it is.

Three sticky status flags record pointer events: the pointer reaching the last index, the pointer returning to index 0, and the pointer reaching a programmable watermark index. A flag is raised only when its condition becomes true. Software clears a flag by writing 0 to its bit. A DMA completion pulse clears all flags when DMA service is enabled. A DMA request output is raised while DMA service is on and any flag picked by the request enables is set.

Top module: `dacbuf_ctrl`

## Requirements
- R1: Word n is written at address 2n (bits 7:0 of the word) and at address 2n+1 (bits 11:8, taken from wdata[3:0]). A read of address 2n+1 returns the high nibble in bits 3:0 and zero in bits 7:4.
- R2: After reset the following hold: status reads 0x02, control reads 0x00, limit reads 0x0F, watermark reads 0x00, pointer reads 0x00, all words are 0, and dac_code is 0.
- R3: When control bit 0 (table enable) is 0, dac_code equals word 0. When it is 1, dac_code equals the word at the read pointer.
- R4: While the table is enabled, each trig pulse moves the pointer from p to p+1, or to 0 when p equals the limit. While the table is disabled, trig has no effect on the pointer.
- R5: Status (address 0x20) has bit 2 = watermark flag (pointer equals watermark), bit 1 = top flag (pointer equals 0), bit 0 = bottom flag (pointer equals limit), and bits 7:3 read 0. A condition counts only while the table is enabled. A flag is set on the clock edge after its condition goes from false to true.
- R6: A write to status clears each flag whose written bit is 0. A written 1 leaves the flag unchanged.
- R7: When dma_done is high and control bit 1 (DMA enable) is 1, all flags clear. When DMA enable is 0, dma_done has no effect.
- R8: If a flag is set and cleared in the same cycle, by software or by DMA, the flag ends up set.
- R9: dma_req is high exactly when DMA enable is 1 and at least one flag is set whose request enable is 1. The request enables are control bit 2 for bottom, bit 3 for top and bit 4 for watermark.
- R10: Register map: 0x21 holds control (bits 4:0, read back, upper bits 0), 0x22 holds the limit and 0x23 the watermark (both bits 3:0), and 0x24 returns the read pointer and cannot be written. All other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| trig | input | 1 | Pointer advance pulse |
| dma_done | input | 1 | DMA completion pulse |
| dac_code | output | 12 | DAC code driven to the converter |
| dma_req | output | 1 | DMA service request |

## Verification
The hardest case to reach is a flag set coinciding with a clear. A pointer condition turns true one edge after the trigger that causes it, so a status write or a DMA completion must land on exactly that following edge. Directed sequences count triggers up to the watermark and to the limit and then place the clear on the critical cycle. Random traffic mixes triggers, limit and watermark rewrites, status writes and DMA pulses, so that rising conditions are also created by reprogramming the limit or watermark rather than only by moving the pointer.

// File: rtl/dacbuf_pkg.sv
package dacbuf_pkg;

  // control register image, LSB first: table enable, DMA enable, request enables
  typedef struct packed {
    logic [2:0] req_en;  // [0] bottom, [1] top, [2] watermark
    logic       dma_en;
    logic       buf_en;
  } ctrl_t;

  localparam int FLAG_BOT = 0;
  localparam int FLAG_TOP = 1;
  localparam int FLAG_WM  = 2;
  localparam int NFLAG    = 3;

  // pointer step: wrap to zero after the last index, else count modulo depth
  function automatic int unsigned wrap_next(input int unsigned p,
                                            input int unsigned last,
                                            input int unsigned depth);
    if (p == last) return 0;
    return (p + 1) % depth;
  endfunction

  // conditions that turned true since the previous cycle
  function automatic logic [NFLAG-1:0] rise(input logic [NFLAG-1:0] now_c,
                                            input logic [NFLAG-1:0] prev_c);
    return now_c & ~prev_c;
  endfunction

  // merge of set and clear requests; a set always survives
  function automatic logic [NFLAG-1:0] flag_next(input logic [NFLAG-1:0] cur,
                                                 input logic [NFLAG-1:0] clr,
                                                 input logic [NFLAG-1:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/dacbuf_words.sv
module dacbuf_words #(
  parameter int DEPTH = 16,
  parameter int DW    = 12,
  parameter int AW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [AW-1:0]              addr,
  input  logic [7:0]                 wdata,
  input  logic                       buf_en,
  input  logic [$clog2(DEPTH)-1:0]   rd_ptr,
  output logic [DW-1:0]              dac_code,
  output logic                       hit,
  output logic [7:0]                 rd_byte
);
  localparam int PW = $clog2(DEPTH);
  localparam int HW = DW - 8;

  logic [DW-1:0] word_q [DEPTH];
  logic [PW-1:0] idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic wr_lo, wr_hi;
    assign wr_lo = we && (addr == AW'(2 * g));
    assign wr_hi = we && (addr == AW'(2 * g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g] <= '0;
      end else begin
        if (wr_lo) word_q[g][7:0]    <= wdata;
        if (wr_hi) word_q[g][DW-1:8] <= wdata[HW-1:0];
      end
    end
  end

  assign idx = addr[PW:1];
  assign hit = (addr < AW'(2 * DEPTH));

  always_comb begin
    if (!hit)         rd_byte = '0;
    else if (addr[0]) rd_byte = {{(8 - HW){1'b0}}, word_q[idx][DW-1:8]};
    else              rd_byte = word_q[idx][7:0];
  end

  assign dac_code = buf_en ? word_q[rd_ptr] : word_q[0];

endmodule

// File: rtl/dacbuf_rdptr.sv
module dacbuf_rdptr import dacbuf_pkg::*; #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       trig,
  input  logic                       buf_en,
  input  logic [$clog2(DEPTH)-1:0]   last_idx,
  input  logic [$clog2(DEPTH)-1:0]   wm_idx,
  output logic [$clog2(DEPTH)-1:0]   ptr,
  output logic                       adv,
  output logic [NFLAG-1:0]           cond,
  output logic [NFLAG-1:0]           set_evt
);
  localparam int PW = $clog2(DEPTH);

  logic [PW-1:0]    ptr_nxt;
  logic [NFLAG-1:0] cond_q;

  assign adv     = trig && buf_en;
  assign ptr_nxt = PW'(wrap_next(int'(ptr), int'(last_idx), DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= ptr_nxt;
  end

  always_comb begin
    cond = '0;
    if (buf_en) begin
      cond[FLAG_BOT] = (ptr == last_idx);
      cond[FLAG_TOP] = (ptr == '0);
      cond[FLAG_WM]  = (ptr == wm_idx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= '0;
    else        cond_q <= cond;
  end

  assign set_evt = rise(cond, cond_q);

endmodule

// File: rtl/dacbuf_flags.sv
module dacbuf_flags import dacbuf_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_evt,
  input  logic             sw_we,
  input  logic [NFLAG-1:0] sw_keep,
  input  logic             dma_clr,
  output logic [NFLAG-1:0] flags
);
  logic [NFLAG-1:0] clr;

  always_comb begin
    clr = '0;
    if (sw_we)   clr = clr | ~sw_keep;
    if (dma_clr) clr = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= NFLAG'(1 << FLAG_TOP);
    else        flags <= flag_next(flags, clr, set_evt);
  end

endmodule

// File: rtl/dacbuf_ctrl.sv
module dacbuf_ctrl import dacbuf_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int DW    = 12,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          trig,
  input  logic          dma_done,
  output logic [DW-1:0] dac_code,
  output logic          dma_req
);
  localparam int PW     = $clog2(DEPTH);
  localparam int A_STAT = 2 * DEPTH;
  localparam int A_CTRL = A_STAT + 1;
  localparam int A_LIM  = A_STAT + 2;
  localparam int A_WM   = A_STAT + 3;
  localparam int A_PTR  = A_STAT + 4;
  localparam int CW     = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic [PW-1:0]    lim_q, wm_q, ptr;
  logic [NFLAG-1:0] cond, set_evt, flags;
  logic             adv, stat_we, dma_clr, word_hit;
  logic [7:0]       word_rd;

  // control, limit and watermark registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lim_q  <= PW'(DEPTH - 1);
      wm_q   <= '0;
    end else if (bus_we) begin
      if (bus_addr == AW'(A_CTRL)) ctrl_q <= ctrl_t'(bus_wdata[CW-1:0]);
      if (bus_addr == AW'(A_LIM))  lim_q  <= bus_wdata[PW-1:0];
      if (bus_addr == AW'(A_WM))   wm_q   <= bus_wdata[PW-1:0];
    end
  end

  dacbuf_words #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_words (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .buf_en   (ctrl_q.buf_en),
    .rd_ptr   (ptr),
    .dac_code (dac_code),
    .hit      (word_hit),
    .rd_byte  (word_rd)
  );

  dacbuf_rdptr #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (trig),
    .buf_en   (ctrl_q.buf_en),
    .last_idx (lim_q),
    .wm_idx   (wm_q),
    .ptr      (ptr),
    .adv      (adv),
    .cond     (cond),
    .set_evt  (set_evt)
  );

  assign stat_we = bus_we && (bus_addr == AW'(A_STAT));
  assign dma_clr = dma_done && ctrl_q.dma_en;

  dacbuf_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (set_evt),
    .sw_we   (stat_we),
    .sw_keep (bus_wdata[NFLAG-1:0]),
    .dma_clr (dma_clr),
    .flags   (flags)
  );

  assign dma_req = ctrl_q.dma_en && |(flags & ctrl_q.req_en);

  always_comb begin
    if (word_hit)                     bus_rdata = word_rd;
    else if (bus_addr == AW'(A_STAT)) bus_rdata = {{(8 - NFLAG){1'b0}}, flags};
    else if (bus_addr == AW'(A_CTRL)) bus_rdata = {{(8 - CW){1'b0}}, ctrl_q};
    else if (bus_addr == AW'(A_LIM))  bus_rdata = {{(8 - PW){1'b0}}, lim_q};
    else if (bus_addr == AW'(A_WM))   bus_rdata = {{(8 - PW){1'b0}}, wm_q};
    else if (bus_addr == AW'(A_PTR))  bus_rdata = {{(8 - PW){1'b0}}, ptr};
    else                              bus_rdata = '0;
  end

endmodule

// File: rtl/dacbuf_chk.sv
module dacbuf_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 12,
  parameter int AW    = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     stat_we,
  input logic [7:0]               bus_wdata,
  input logic [AW-1:0]            bus_addr,
  input logic [7:0]               bus_rdata,
  input logic                     adv,
  input logic [$clog2(DEPTH)-1:0] ptr,
  input logic [$clog2(DEPTH)-1:0] lim,
  input logic [2:0]               set_evt,
  input logic [2:0]               flags,
  input logic                     dma_clr,
  input logic                     dma_en,
  input logic                     dma_req
);

  // R5: a rising condition shows up in the flag on the next edge
  a_r5_set_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_evt) |=> ((flags & $past(set_evt)) == $past(set_evt)));

  // R5: no flag rises without a set event
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (flags != 3'b111) |=> ((flags & ~$past(flags) & ~$past(set_evt)) == 3'b000));

  // R5: reserved status bits
  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(2 * DEPTH)) |-> (bus_rdata[7:3] == 5'b0));

  // R6: writing ones keeps flags
  a_r6_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && !dma_clr) |=>
      ((flags & $past(flags & bus_wdata[2:0])) == $past(flags & bus_wdata[2:0])));

  // R7: DMA completion empties the flags
  a_r7_dma_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_clr && set_evt == 3'b000) |=> (flags == 3'b000));

  // R8: set beats clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_we || dma_clr) && (|set_evt)) |=> ((flags & $past(set_evt)) == $past(set_evt)));

  // R4: pointer holds without an advance
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr));

  // R4: wrap after the last index
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr == lim) |=> (ptr == '0));

  // R9: no request without DMA service
  a_r9_req_needs_dma: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !dma_req);

  // R1: high half of a word reads zero above the nibble
  a_r1_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < AW'(2 * DEPTH) && bus_addr[0]) |-> (bus_rdata[7:DW-8] == '0));

endmodule

bind dacbuf_ctrl dacbuf_chk #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stat_we   (stat_we),
  .bus_wdata (bus_wdata),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .adv       (adv),
  .ptr       (ptr),
  .lim       (lim_q),
  .set_evt   (set_evt),
  .flags     (flags),
  .dma_clr   (dma_clr),
  .dma_en    (ctrl_q.dma_en),
  .dma_req   (dma_req)
);

// File: tb/sim_dacbuf_ctrl.sv
module sim_dacbuf_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        trig = 1'b0;
  logic        dma_done = 1'b0;
  logic [7:0]  bus_rdata;
  logic [11:0] dac_code;
  logic        dma_req;

  always #5 clk = ~clk;

  dacbuf_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig(trig),
    .dma_done(dma_done), .dac_code(dac_code), .dma_req(dma_req)
  );

  // reference state built from the requirements
  logic [11:0] m_mem [16];
  logic        m_en, m_dmaen;
  logic [2:0]  m_req, m_flg, m_prev;
  logic [3:0]  m_lim, m_wm, m_ptr;

  int n_cmp = 0;
  int n_bad = 0;
  bit    k_on = 0;
  string k_tag;
  int    k_exp;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < 16; i++) m_mem[i] = '0;
    m_en = 0; m_dmaen = 0; m_req = '0; m_flg = 3'b010; m_prev = '0;
    m_lim = 4'hF; m_wm = '0; m_ptr = '0;
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a < 8'd32) return a[0] ? {4'b0, m_mem[a[4:1]][11:8]} : m_mem[a[4:1]][7:0];
    case (a)
      8'h20: return {5'b0, m_flg};
      8'h21: return {3'b0, m_req, m_dmaen, m_en};
      8'h22: return {4'b0, m_lim};
      8'h23: return {4'b0, m_wm};
      8'h24: return {4'b0, m_ptr};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a < 8'd32) return "R1";
    if (a == 8'h20) return "R5";
    return "R10";
  endfunction

  task automatic m_step(input bit we, input logic [7:0] a, input logic [7:0] d,
                        input bit t, input bit dm);
    logic [2:0] c, s, clr;
    c = '0;
    if (m_en) c = {m_ptr == m_wm, m_ptr == 4'd0, m_ptr == m_lim};
    s = c & ~m_prev;
    m_prev = c;
    clr = '0;
    if (we && a == 8'h20) clr = ~d[2:0];
    if (dm && m_dmaen) clr = 3'b111;
    m_flg = (m_flg & ~clr) | s;
    if (t && m_en) m_ptr = (m_ptr == m_lim) ? 4'd0 : m_ptr + 4'd1;
    if (we) begin
      if (a < 8'd32) begin
        if (a[0]) m_mem[a[4:1]][11:8] = d[3:0];
        else      m_mem[a[4:1]][7:0]  = d;
      end
      if (a == 8'h21) {m_req, m_dmaen, m_en} = d[4:0];
      if (a == 8'h22) m_lim = d[3:0];
      if (a == 8'h23) m_wm  = d[3:0];
    end
  endtask

  // one clock: drive at the falling edge, compare, then let the edge update state
  task automatic cyc(input bit we, input logic [7:0] a, input logic [7:0] d,
                     input bit t, input bit dm);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; trig = t; dma_done = dm;
    #1;
    chk(tag_of(a), bus_rdata, exp_rd(a));
    chk("R3", dac_code, m_en ? m_mem[m_ptr] : m_mem[0]);
    chk("R9", dma_req, m_dmaen && |(m_flg & m_req));
    if (k_on) begin
      chk(k_tag, bus_rdata, k_exp);
      k_on = 0;
    end
    @(posedge clk);
    m_step(we, a, d, t, dm);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cyc(1, a, d, 0, 0);
  endtask

  task automatic rd_expect(input string tag, input logic [7:0] a, input int exp);
    k_on = 1; k_tag = tag; k_exp = exp;
    cyc(0, a, 8'h00, 0, 0);
  endtask

  task automatic fire(input int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h24, 8'h00, 1, 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R2", dac_code, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 reset image
    rd_expect("R2", 8'h20, 8'h02);
    rd_expect("R2", 8'h21, 8'h00);
    rd_expect("R2", 8'h22, 8'h0F);
    rd_expect("R2", 8'h24, 8'h00);

    // R1 split word write, upper nibble discarded
    wr(8'h00, 8'hBC);
    wr(8'h01, 8'hFA);
    rd_expect("R1", 8'h01, 8'h0A);
    rd_expect("R1", 8'h00, 8'hBC);

    // R6 ones have no effect, zero clears
    wr(8'h20, 8'hFF);
    rd_expect("R6", 8'h20, 8'h02);
    wr(8'h20, 8'h00);
    rd_expect("R6", 8'h20, 8'h00);

    // R10 pointer register is read-only; unmapped reads zero
    wr(8'h24, 8'h07);
    rd_expect("R10", 8'h24, 8'h00);
    rd_expect("R10", 8'h3F, 8'h00);

    // fill the table
    for (int i = 0; i < 16; i++) begin
      wr(8'(2 * i), 8'(8'h11 * i + 3));
      wr(8'(2 * i + 1), 8'(i));
    end
    // R4 disabled: trig ignored, R3 bypass shows word 0
    fire(3);
    rd_expect("R4", 8'h24, 8'h00);

    wr(8'h22, 8'h05);
    wr(8'h23, 8'h03);
    wr(8'h21, 8'h1F);
    wr(8'h20, 8'h00);   // top rises on enable, set wins over this clear (R8)
    rd_expect("R8", 8'h20, 8'h02);
    wr(8'h20, 8'h00);
    fire(2);            // pointer 2
    fire(1);            // pointer 3, watermark condition rises
    wr(8'h20, 8'h00);   // clear on the same edge as the set
    rd_expect("R8", 8'h20, 8'h04);
    cyc(0, 8'h20, 8'h00, 0, 1);
    rd_expect("R7", 8'h20, 8'h00);

    // R7 DMA disabled: completion ignored
    wr(8'h21, 8'h1D);
    fire(2);            // pointer 5 = limit, bottom rises
    cyc(0, 8'h20, 8'h00, 0, 0);
    cyc(0, 8'h20, 8'h00, 0, 1);
    rd_expect("R7", 8'h20, 8'h01);
    fire(1);
    rd_expect("R4", 8'h24, 8'h00);  // wrapped after the limit

    // R9 request follows enables
    wr(8'h21, 8'h07);
    rd_expect("R9", 8'h20, 8'h03);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [7:0]  a, d;
      bit we;
      r  = $urandom_range(0, 99);
      we = (r < 35);
      a  = 8'($urandom_range(0, 40));
      if (r < 10) a = 8'($urandom_range(32, 35));
      d  = 8'($urandom);
      if (we && a == 8'h21) d[0] = ($urandom_range(0, 9) != 0);
      cyc(we, a, d, $urandom_range(0, 2) == 0, $urandom_range(0, 15) == 0);
    end

    summary();
    $finish;
  end
endmodule